// File: doc/BRIEF.md
# Serial Polyphase Resampling Filter Bank

This block is an M-path polyphase filter bank that changes sample rate by a rational ratio using scheduling alone. Every output frame takes in N new input samples and produces one result from each of the M paths. N is a runtime setting and may be below, equal to or above M, so the bank runs under-decimated, maximally decimated or over-decimated with the same hardware. A commutator steers each accepted sample into one path's delay line. A scheduler then walks a single shared multiply-accumulate unit through every tap of every path.

Each delay line is a circular buffer in one shared state memory. The write pointers and fill levels of all paths are copied when a frame completes, so the computation reads a frozen view of the state while later samples land in free slots. There are two schedules. In load-first mode, input is refused while a frame is being computed, so the processing clock must be a multiple of the input rate. In overlap mode, the next frame keeps loading while the current one is computed, so the clock can run slower. Coefficient design and any stage after the bank are outside the block.

Top module: `pp_resampler`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is low and in_ready is high. After reset every delay-line tap reads as zero.
- R2: The commutator puts the j-th sample accepted since reset into path j mod M. The starting path of each frame therefore moves on by N mod M. When N exceeds M, a path receives more than one sample in the same frame.
- R3: The result of path m is the sum over t < T of h[m][t]·x_m[t]. Here x_m[0] is the newest sample in path m and h[m][t] is the signed 16-bit field coef_i[(m·T+t)·16 +: 16]. Taps that have never been written count as zero.
- R4: With sched_i = 0 (load-first), in_ready goes low in the cycle after the N-th sample of a frame is accepted. It stays low until all M results of that frame have been issued.
- R5: With sched_i = 1 (overlap), in_ready stays high while a frame is being computed. It drops only when the following frame is fully loaded before that computation ends.
- R6: Each completed frame yields exactly M pulses of out_valid, with out_path counting 0 to M−1 in order. No frame is dropped in either mode.
- R7: Results are correct for N below, equal to and above M, with N held constant from reset.
- R8: Samples accepted while a frame is being computed do not change that frame's results.
- R9: Results are signed and at full precision in a 36-bit accumulator. This holds even when every product is (−32768)·(−32768).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_i | input | 1 | 0 = load-first, 1 = overlap |
| n_cfg_i | input | 4 | Samples per frame N (1..15), held from reset |
| coef_i | input | 512 | Coefficients, path-major, tap 0 multiplies newest |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Result valid (one cycle per path) |
| out_data | output | 36 | Signed path result |
| out_path | output | 3 | Path index of out_data |

## Verification
The bench sweeps both schedules with N of 1, 4, 8, 12 and 15. It covers the cases where the commutator start offset wraps part-way through a frame and where it wraps more than once per frame. A wrong path rotation or pointer snapshot shows up as results built from the wrong samples. A missing fill mask shows up as stale memory contents in the first frames. In overlap mode the second frame completes while the first is still being computed. A scheduler that dropped or merged frames there would deliver fewer than M results per frame, and one that did not freeze the state would leak new samples into the older frame. The ready behaviour is checked right after each of the first two frames. A run with all operands at the most negative value exposes any truncation of the accumulator.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    SCHED_LOAD_FIRST = 1'b0,
    SCHED_OVERLAP    = 1'b1
  } sched_e;
endpackage

// File: rtl/pp_state_ram.sv
module pp_state_ram #(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_commutator.sv
module pp_commutator #(
  parameter int M_PATHS = 8,
  parameter int DEPTH   = 8,
  parameter int TAPS    = 4,
  parameter int NW      = 4,
  localparam int PW  = $clog2(M_PATHS),
  localparam int DPW = $clog2(DEPTH),
  localparam int FW  = $clog2(TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NW-1:0]     n_cfg,
  input  logic              take_snap,
  output logic [PW+DPW-1:0] wr_addr,
  output logic              frame_done,
  output logic [DPW-1:0]    snap_ptr  [M_PATHS],
  output logic [FW-1:0]     snap_fill [M_PATHS]
);
  logic [PW-1:0]  path_q;
  logic [NW-1:0]  kc_q;
  logic [DPW-1:0] ptr_q  [M_PATHS];
  logic [DPW-1:0] ptr_d  [M_PATHS];
  logic [FW-1:0]  fill_q [M_PATHS];
  logic [FW-1:0]  fill_d [M_PATHS];

  assign wr_addr    = {path_q, ptr_q[path_q]};
  assign frame_done = wr_en && (kc_q == n_cfg - NW'(1));

  always_comb begin
    for (int m = 0; m < M_PATHS; m++) begin
      ptr_d[m]  = ptr_q[m];
      fill_d[m] = fill_q[m];
      if (wr_en && path_q == PW'(m)) begin
        ptr_d[m] = ptr_q[m] + DPW'(1);
        if (fill_q[m] != FW'(TAPS)) fill_d[m] = fill_q[m] + FW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      path_q <= '0;
      kc_q   <= '0;
    end else if (wr_en) begin
      path_q <= (path_q == PW'(M_PATHS - 1)) ? '0 : path_q + PW'(1);
      kc_q   <= frame_done ? '0 : kc_q + NW'(1);
    end
  end

  for (genvar g = 0; g < M_PATHS; g++) begin : g_path
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g]     <= '0;
        fill_q[g]    <= '0;
        snap_ptr[g]  <= '0;
        snap_fill[g] <= '0;
      end else begin
        ptr_q[g]  <= ptr_d[g];
        fill_q[g] <= fill_d[g];
        if (take_snap) begin
          snap_ptr[g]  <= ptr_d[g];
          snap_fill[g] <= fill_d[g];
        end
      end
    end
  end
endmodule

// File: rtl/pp_mac.sv
module pp_mac #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 36,
  parameter int PW = 3,
  localparam int MW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic                 op_first,
  input  logic                 op_last,
  input  logic                 op_mask,
  input  logic [PW-1:0]        op_path,
  input  logic [CW-1:0]        op_coef,
  input  logic [DW-1:0]        rd_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data,
  output logic [PW-1:0]        out_path
);
  logic                 s_valid, s_first, s_last, s_mask;
  logic [PW-1:0]        s_path;
  logic [CW-1:0]        s_coef;
  logic signed [MW-1:0] prod;
  logic signed [AW-1:0] prod_ext, acc_q, acc_d;

  always_comb begin
    prod     = $signed(rd_data) * $signed(s_coef);
    prod_ext = s_mask ? {{(AW-MW){prod[MW-1]}}, prod} : '0;
    acc_d    = (s_first ? '0 : acc_q) + prod_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid   <= 1'b0;
      out_valid <= 1'b0;
      acc_q     <= '0;
    end else begin
      s_valid   <= op_valid;
      out_valid <= s_valid && s_last;
      if (s_valid) acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk) begin
    s_first <= op_first;
    s_last  <= op_last;
    s_mask  <= op_mask;
    s_path  <= op_path;
    s_coef  <= op_coef;
    if (s_valid && s_last) begin
      out_data <= acc_d;
      out_path <= s_path;
    end
  end
endmodule

// File: rtl/pp_resampler.sv
module pp_resampler #(
  parameter int M_PATHS = 8,
  parameter int TAPS    = 4,
  parameter int DEPTH   = 8,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int AW      = 36,
  parameter int NW      = 4,
  localparam int PW  = $clog2(M_PATHS),
  localparam int DPW = $clog2(DEPTH),
  localparam int TW  = $clog2(TAPS),
  localparam int FW  = $clog2(TAPS + 1),
  localparam int RAW = PW + DPW
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sched_i,
  input  logic [NW-1:0]                n_cfg_i,
  input  logic [M_PATHS*TAPS*CW-1:0]   coef_i,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [DW-1:0]                in_data,
  output logic                         out_valid,
  output logic signed [AW-1:0]         out_data,
  output logic [PW-1:0]                out_path
);
  import pp_pkg::*;

  sched_e         sched;
  logic           busy_q, pend_q, issue_last, start, wr_en, frame_done;
  logic [PW-1:0]  pc_q;
  logic [TW-1:0]  tc_q;
  logic [RAW-1:0] waddr, raddr;
  logic [DPW-1:0] slot;
  logic [DPW-1:0] snap_ptr  [M_PATHS];
  logic [FW-1:0]  snap_fill [M_PATHS];
  logic [CW-1:0]  coef_sel;
  logic           tap_mask;
  logic [DW-1:0]  rd_data;

  assign sched      = sched_e'(sched_i);
  assign in_ready   = (sched == SCHED_OVERLAP) ? !pend_q : (!busy_q && !pend_q);
  assign wr_en      = in_valid && in_ready;
  assign issue_last = busy_q && pc_q == PW'(M_PATHS - 1) && tc_q == TW'(TAPS - 1);
  assign start      = (pend_q || frame_done) && (!busy_q || issue_last);

  always_comb begin
    int idx;
    idx      = int'(pc_q) * TAPS + int'(tc_q);
    coef_sel = coef_i[idx*CW +: CW];
    slot     = snap_ptr[pc_q] - DPW'(tc_q) - DPW'(1);
    raddr    = {pc_q, slot};
    tap_mask = FW'(tc_q) < snap_fill[pc_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      pc_q   <= '0;
      tc_q   <= '0;
    end else begin
      pend_q <= (pend_q || frame_done) && !start;
      if (start)           busy_q <= 1'b1;
      else if (issue_last) busy_q <= 1'b0;
      if (busy_q) begin
        if (tc_q == TW'(TAPS - 1)) begin
          tc_q <= '0;
          pc_q <= (pc_q == PW'(M_PATHS - 1)) ? '0 : pc_q + PW'(1);
        end else begin
          tc_q <= tc_q + TW'(1);
        end
      end
    end
  end

  pp_commutator #(.M_PATHS(M_PATHS), .DEPTH(DEPTH), .TAPS(TAPS), .NW(NW)) u_comm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .n_cfg(n_cfg_i), .take_snap(start),
    .wr_addr(waddr), .frame_done(frame_done),
    .snap_ptr(snap_ptr), .snap_fill(snap_fill)
  );

  pp_state_ram #(.AW(RAW), .W(DW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata(in_data),
    .raddr(raddr), .rdata(rd_data)
  );

  pp_mac #(.DW(DW), .CW(CW), .AW(AW), .PW(PW)) u_mac (
    .clk(clk), .rst(rst), .op_valid(busy_q),
    .op_first(tc_q == '0), .op_last(tc_q == TW'(TAPS - 1)),
    .op_mask(tap_mask), .op_path(pc_q), .op_coef(coef_sel),
    .rd_data(rd_data), .out_valid(out_valid), .out_data(out_data),
    .out_path(out_path)
  );
endmodule

// File: rtl/pp_resampler_chk.sv
module pp_resampler_chk #(
  parameter int M_PATHS = 8,
  localparam int PW = $clog2(M_PATHS)
) (
  input logic          clk,
  input logic          rst,
  input logic          sched_i,
  input logic          in_ready,
  input logic          out_valid,
  input logic [PW-1:0] out_path,
  input logic          busy,
  input logic          pend
);
  logic [PW-1:0] next_path;

  always_ff @(posedge clk) begin
    if (rst) next_path <= '0;
    else if (out_valid)
      next_path <= (out_path == PW'(M_PATHS - 1)) ? '0 : out_path + PW'(1);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!out_valid && in_ready)); // R1
  AST_LOADFIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sched_i && busy) |-> !in_ready); // R4
  AST_OVERLAP_OPEN: assert property (@(posedge clk) disable iff (rst)
    (sched_i && busy && !pend) |-> in_ready); // R5
  AST_PENDING_BLOCK: assert property (@(posedge clk) disable iff (rst)
    pend |-> !in_ready); // R5
  AST_PATH_ORDER: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_path == next_path); // R6
endmodule

bind pp_resampler pp_resampler_chk #(.M_PATHS(M_PATHS)) u_chk (
  .clk(clk), .rst(rst), .sched_i(sched_i), .in_ready(in_ready),
  .out_valid(out_valid), .out_path(out_path), .busy(busy_q), .pend(pend_q)
);

// File: tb/pp_resampler_test.sv
`timescale 1ns/1ps
module pp_resampler_test;
  localparam int M = 8, T = 4;

  logic clk = 0, rst = 1, sched = 0, in_valid = 0, in_ready, out_valid;
  logic [3:0] n_cfg = 4'd8;
  logic [M*T*16-1:0] coef = '0;
  logic signed [15:0] in_data = 0;
  logic signed [35:0] out_data;
  logic [2:0] out_path;

  int compared = 0, mismatched = 0, received = 0, expected_total = 0;
  int mpath, mk;
  logic signed [15:0] hist [M][T];
  logic signed [15:0] h [M][T];
  longint exp_v[$];
  int exp_p[$];
  logic finished = 0;
  int unsigned lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pp_resampler uut (
    .clk(clk), .rst(rst), .sched_i(sched), .n_cfg_i(n_cfg), .coef_i(coef),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_path(out_path)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_push(input logic signed [15:0] x, output bit fend);
    for (int t = T - 1; t > 0; t--) hist[mpath][t] = hist[mpath][t-1];
    hist[mpath][0] = x;
    mpath = (mpath + 1) % M;
    mk++;
    fend = 0;
    if (mk == int'(n_cfg)) begin
      mk = 0; fend = 1;
      for (int m = 0; m < M; m++) begin
        longint acc = 0;
        for (int t = 0; t < T; t++) acc += longint'(hist[m][t]) * longint'(h[m][t]);
        exp_v.push_back(acc); exp_p.push_back(m);
        expected_total++;
      end
    end
  endtask

  task automatic send(input logic signed [15:0] x, output bit fend);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = x;
    model_push(x, fend);
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic run(input bit md, input int n, input int frames, input bit extreme);
    bit fend;
    int fcount = 0;
    sched = md; n_cfg = 4'(n);
    for (int m = 0; m < M; m++)
      for (int t = 0; t < T; t++) begin
        h[m][t] = extreme ? -16'sd32768 : 16'(((m + 1) * 911 - t * 4099 + m * t * 77) % 30000);
        coef[(m*T+t)*16 +: 16] = h[m][t];
        hist[m][t] = 0;
      end
    mpath = 0; mk = 0; received = 0; expected_total = 0;
    exp_v.delete(); exp_p.delete();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R1 reset idle", {out_valid, in_ready}, 1);
    rst = 0;
    for (int i = 0; i < frames * n; i++) begin
      lcg = lcg * 1103515245 + 12345;
      send(extreme ? -16'sd32768 : 16'(lcg[30:15]), fend);
      if (fend) begin
        @(negedge clk);
        if (!md)
          check(in_ready == 0, "R4 load-first stalls input", in_ready, 0);
        else if (fcount == 0)
          check(in_ready == 1, "R5 overlap keeps accepting", in_ready, 1);
        else if (fcount == 1)
          check(in_ready == 0, "R5 overlap blocks when next frame ready", in_ready, 0);
        fcount++;
      end
    end
    for (int w = 0; w < 400 && exp_v.size() != 0; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(received == expected_total, "R6 result count per frame (no drop)", received, expected_total);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      received++;
      if (exp_v.size() == 0) begin
        check(0, "R6 unexpected result", out_data, 0);
      end else begin
        longint ev; int ep;
        ev = exp_v.pop_front(); ep = exp_p.pop_front();
        check(int'(out_path) == ep, "R6 path tag order", out_path, ep);
        check(longint'(out_data) == ev, "R3/R7/R8/R9 path result", out_data, ev);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R2 R7: sweep ratios below, at and above M, both schedules
    for (int md = 0; md < 2; md++) begin
      run(md[0], 4, 6, 0);
      run(md[0], 8, 5, 0);
      run(md[0], 12, 5, 0);
      run(md[0], 1, 10, 0);
      run(md[0], 15, 4, 0);
    end
    // R9: most negative operands everywhere, full-precision sum 2^32
    run(0, 8, 3, 1);
    run(1, 12, 3, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule